// File: doc/BRIEF.md
# Double-Buffered Crosspoint Route Controller

This block is the digital control core of an 8-input by 4-output crosspoint switch. A host stages one routing entry per output in a staging bank. A single salvo strobe then copies every staged entry into the active bank in the same clock edge. The active bank drives the 32 crosspoint enables and the four active-low per-output disable flags. Because the copy happens in one edge, all outputs change their routing together. Several of these blocks can share one salvo line, so a larger matrix switches in a single step.

Each routing entry is 4 bits wide. The top bit means "off". The lower three bits are the zero-based number of the selected input. A matrix clear input opens every crosspoint and empties the active bank, but it leaves the staging bank untouched. A salvo issued after the clear therefore restores the earlier routing. When the host selects read direction, the bidirectional address port returns the active entry of the addressed output. The bidirectional port is modelled as separate data-in, data-out and output-enable signals. Strobe levels are sampled on every rising edge of the system clock.

Top module: `xpt_ctrl`

## Requirements
- R1: Entry code 4'b0sss on output o sets crosspoint enable bit o*8+sss and no other bit of that output's 8-bit slice. Any code with bit 3 set turns output o off, whatever bits 2..0 hold.
- R2: On each clock edge where cs_n=0, rd_wr=0, clr_n=1 and wr_n=0, the staging entry for output out_sel (0..3) takes addr_i. It keeps that value in every cycle where these conditions do not all hold.
- R3: Staged entries do not reach the crosspoints while salvo_n is high. On every edge where salvo_n is low and clr_n is high, the whole active bank takes the whole staging bank, so all outputs change in the same cycle.
- R4: While clr_n is low, xpt_en is all zero and off_n is all zero in the same cycle. The active bank is cleared to all-off. The staging bank is kept, so a salvo after clr_n returns high re-applies the staged routing.
- R5: With cs_n=0 and rd_wr=1, addr_oe is 1 and addr_o carries the active entry of output out_sel. All-off reads back as 4'b1000.
- R6: In every other combination of cs_n and rd_wr, addr_oe is 0 and addr_o is 0.
- R7: off_n[o] is 0 exactly when output o has no crosspoint enabled.
- R8: An output enables at most one input at a time, and one input may feed all four outputs together.
- R9: After arst_n (power-up reset), both banks hold all-off: no crosspoint is enabled, every readback is 4'b1000, and a salvo before any write enables nothing.
- R10: A write strobe has no effect on the staging bank while cs_n is high, rd_wr is high, or clr_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Power-up reset, active low; initialises both banks to all-off |
| cs_n | input | 1 | Chip select, active low |
| rd_wr | input | 1 | Direction: 0 for a staging write, 1 for an active-bank readback |
| wr_n | input | 1 | Write strobe, active low |
| salvo_n | input | 1 | Salvo strobe, active low; copies staging into active |
| clr_n | input | 1 | Matrix clear, active low; opens all crosspoints |
| out_sel | input | 2 | Output address |
| addr_i | input | 4 | Input address / entry code, write data |
| addr_o | output | 4 | Readback data |
| addr_oe | output | 1 | Output enable for the address port |
| xpt_en | output | 32 | Crosspoint enables; bit out*8+in |
| off_n | output | 4 | Per-output disable flags, low when the output is unconnected |

## Verification
The hardest state to reach from the ports is a staging bank that differs from the active bank while a clear is in force. Only then can the bench show that the clear left the staged routing intact. The bench first commits a known routing with a salvo. It then holds clr_n low, checks that every output is dark and that every readback shows all-off, and tries a write during the clear. After it releases clr_n, one salvo must bring back the exact routing from before the clear. A second awkward case is holding salvo_n low for a long time, so that a later staging write passes into the active bank one cycle after it lands.

// File: rtl/xpt_ctrl.sv
module xpt_ctrl #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 4,
  localparam int SEL_W  = $clog2(N_IN),
  localparam int OSEL_W = $clog2(N_OUT),
  localparam int ENT_W  = SEL_W + 1
) (
  input  logic                   clk,
  input  logic                   arst_n,
  input  logic                   cs_n,
  input  logic                   rd_wr,
  input  logic                   wr_n,
  input  logic                   salvo_n,
  input  logic                   clr_n,
  input  logic [OSEL_W-1:0]      out_sel,
  input  logic [ENT_W-1:0]       addr_i,
  output logic [ENT_W-1:0]       addr_o,
  output logic                   addr_oe,
  output logic [N_OUT*N_IN-1:0]  xpt_en,
  output logic [N_OUT-1:0]       off_n
);

  localparam logic [ENT_W-1:0] OFF = {1'b1, {SEL_W{1'b0}}};
  localparam logic [N_OUT-1:0][ENT_W-1:0] ALL_OFF = {N_OUT{OFF}};

  logic [N_OUT-1:0][ENT_W-1:0] stage_q;
  logic [N_OUT-1:0][ENT_W-1:0] act_q;
  logic                        wr_en;
  logic                        sel_ok;

  assign sel_ok = int'(out_sel) < N_OUT;
  assign wr_en  = !cs_n && !rd_wr && !wr_n && clr_n && sel_ok;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    stage_q <= ALL_OFF;
    else if (wr_en) stage_q[out_sel] <= addr_i;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)       act_q <= ALL_OFF;
    else if (!clr_n)   act_q <= ALL_OFF;
    else if (!salvo_n) act_q <= stage_q;
  end

  assign addr_oe = !cs_n && rd_wr;
  assign addr_o  = (addr_oe && sel_ok) ? act_q[out_sel] : '0;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign off_n[o] = clr_n && !act_q[o][SEL_W];
    for (genvar i = 0; i < N_IN; i++) begin : g_in
      assign xpt_en[o*N_IN+i] = clr_n && !act_q[o][SEL_W] &&
                                (act_q[o][SEL_W-1:0] == SEL_W'(i));
    end

    p_flag_r7: assert property (@(posedge clk) disable iff (!arst_n)
      off_n[o] == (|xpt_en[o*N_IN +: N_IN]));
    p_one_in_r8: assert property (@(posedge clk) disable iff (!arst_n)
      $onehot0(xpt_en[o*N_IN +: N_IN]));
  end

  p_stage_hold_r2: assert property (@(posedge clk) disable iff (!arst_n)
    (cs_n || rd_wr || wr_n || !clr_n) |=> $stable(stage_q));
  p_act_hold_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (salvo_n && clr_n) |=> $stable(act_q));
  p_copy_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (!salvo_n && clr_n) |=> (act_q == $past(stage_q)));
  p_clear_r4: assert property (@(posedge clk) disable iff (!arst_n)
    !clr_n |=> (act_q == ALL_OFF));
  p_rdback_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (addr_oe && clr_n && sel_ok) |-> (addr_o[SEL_W] == !off_n[out_sel]));
  p_quiet_r6: assert property (@(posedge clk) disable iff (!arst_n)
    !addr_oe |-> (addr_o == '0));

endmodule

// File: tb/xpt_ctrl_tb.sv
module xpt_ctrl_tb;
  logic        clk = 0;
  logic        arst_n = 0;
  logic        cs_n = 1, rd_wr = 0, wr_n = 1, salvo_n = 1, clr_n = 1;
  logic [1:0]  out_sel = 0;
  logic [3:0]  addr_i = 0;
  logic [3:0]  addr_o;
  logic        addr_oe;
  logic [31:0] xpt_en;
  logic [3:0]  off_n;
  int n_chk = 0, n_fail = 0;
  logic        done = 0;

  always #5 clk = ~clk;

  xpt_ctrl u_dut (
    .clk(clk), .arst_n(arst_n), .cs_n(cs_n), .rd_wr(rd_wr), .wr_n(wr_n),
    .salvo_n(salvo_n), .clr_n(clr_n), .out_sel(out_sel), .addr_i(addr_i),
    .addr_o(addr_o), .addr_oe(addr_oe), .xpt_en(xpt_en), .off_n(off_n)
  );

  // routing sets, {out3,out2,out1,out0}
  localparam logic [15:0] VEC [8] = '{
    16'h3210, 16'h7777, 16'h0000, 16'h8582,
    16'h0123, 16'h8888, 16'h6F45, 16'h1C9A
  };

  function automatic logic [31:0] exp_en(logic [15:0] v);
    logic [31:0] r = '0;
    for (int o = 0; o < 4; o++)
      if (!v[o*4+3]) r[o*8 + int'(v[o*4 +: 3])] = 1'b1;
    return r;
  endfunction

  function automatic logic [3:0] exp_off(logic [15:0] v);
    logic [3:0] r;
    for (int o = 0; o < 4; o++) r[o] = !v[o*4+3];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int o, logic [3:0] c);
    @(negedge clk);
    cs_n = 0; rd_wr = 0; out_sel = 2'(o); addr_i = c; wr_n = 0;
    @(negedge clk);
    wr_n = 1; cs_n = 1;
  endtask

  task automatic salvo();
    @(negedge clk); salvo_n = 0;
    @(negedge clk); salvo_n = 1;
    #1;
  endtask

  task automatic rdback(int o, logic [3:0] exp, string req);
    @(negedge clk);
    cs_n = 0; rd_wr = 1; out_sel = 2'(o);
    #1;
    chk(req, {31'b0, addr_oe}, 32'd1);
    chk(req, {28'b0, addr_o}, {28'b0, exp});
    cs_n = 1; rd_wr = 0;
  endtask

  task automatic check_state(logic [15:0] v, string req);
    chk(req, xpt_en, exp_en(v));
    chk({req, " off_n R7"}, {28'b0, off_n}, {28'b0, exp_off(v)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    arst_n = 1;
    #1;
    // R9: power-up state
    check_state(16'h8888, "R9 reset");
    for (int o = 0; o < 4; o++) rdback(o, 4'b1000, "R9 readback");
    salvo();
    check_state(16'h8888, "R9 salvo before write");

    // R1 R2 R3 R8: table walk
    for (int k = 0; k < 8; k++) begin
      for (int o = 0; o < 4; o++) wr(o, VEC[k][o*4 +: 4]);
      salvo();
      check_state(VEC[k], "R1 R8 table");
      for (int o = 0; o < 4; o++) rdback(o, VEC[k][o*4 +: 4], "R5 table");
    end

    // R3: staged entry stays hidden until salvo
    for (int o = 0; o < 4; o++) wr(o, VEC[0][o*4 +: 4]);
    salvo();
    wr(2, 4'h6);
    #1 check_state(16'h3210, "R3 hidden before salvo");
    salvo();
    check_state(16'h3610, "R3 commit");

    // R3: salvo held low, active follows staging one cycle later
    @(negedge clk); salvo_n = 0;
    wr(0, 4'h5);
    @(negedge clk); #1;
    check_state(16'h3615, "R3 follow while salvo low");
    @(negedge clk); salvo_n = 1;

    // R6: port quiet unless selected for read
    @(negedge clk); cs_n = 1; rd_wr = 1; #1;
    chk("R6 cs high oe", {31'b0, addr_oe}, 32'd0);
    chk("R6 cs high data", {28'b0, addr_o}, 32'd0);
    cs_n = 0; rd_wr = 0; #1;
    chk("R6 write dir oe", {31'b0, addr_oe}, 32'd0);
    cs_n = 1;

    // R10: writes ignored when deselected or reading
    @(negedge clk); cs_n = 1; rd_wr = 0; out_sel = 1; addr_i = 4'h7; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 0; rd_wr = 1; out_sel = 3; addr_i = 4'h0; wr_n = 0;
    @(negedge clk); wr_n = 1; cs_n = 1; rd_wr = 0;
    salvo();
    check_state(16'h3615, "R10 ignored writes");

    // R4: clear keeps staging, salvo restores it
    @(negedge clk); clr_n = 0; #1;
    chk("R4 clear xpt_en", xpt_en, 32'd0);
    chk("R4 clear off_n", {28'b0, off_n}, 32'd0);
    @(negedge clk);
    for (int o = 0; o < 4; o++) rdback(o, 4'b1000, "R4 cleared readback");
    // R10: write during clear ignored
    @(negedge clk); cs_n = 0; rd_wr = 0; out_sel = 0; addr_i = 4'h2; wr_n = 0;
    @(negedge clk); wr_n = 1; cs_n = 1;
    @(negedge clk); salvo_n = 0;
    @(negedge clk); salvo_n = 1; #1;
    chk("R4 salvo during clear", xpt_en, 32'd0);
    @(negedge clk); clr_n = 1; #1;
    chk("R4 stays off after release", xpt_en, 32'd0);
    salvo();
    check_state(16'h3615, "R4 R10 restore after clear");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule